// File: doc/BRIEF.md
# Banked Secure/Non-Secure Priority Register File

This block stores the per-interface interrupt control word, priority mask, two binary point copies and the distributor enable bits. It also stores one priority byte per interrupt source, for an interrupt controller that may carry a security extension. A single request/response register port reaches all of this storage. Every request carries a security attribute. A secure access sees the stored bits directly. A non-secure access sees a view derived from the same flops: priorities are shifted by one bit and confined to the upper half of the range, and the control words are aliased with their bits moved, so no register is duplicated.

The raw stored values leave the block on plain output buses, where the arbiter uses them. A neighbouring block provides the per-source group membership and the running priority. This block reads both and stores neither.

The request port is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A write takes effect at that edge and produces no response. A read loads `rsp_data` and raises `rsp_valid` at that edge. The response stays valid and unchanged until a cycle in which `rsp_ready` is high. `req_ready` is low only while a response is waiting and `rsp_ready` is low, so a single response slot can never be overwritten.

Top module: `banked_prio_regs`

## Requirements
- R1: After reset, every stored value is zero: the control word, the distributor control, the priority mask, both binary points and all source priorities. `rsp_valid` is low.
- R2: The address map and the handshake behave as follows.
  - Address map (7-bit `req_addr`): 0x00 interface control, 0x01 priority mask, 0x02 binary point, 0x03 aliased binary point, 0x04 running priority (read only), 0x05 distributor control, and 0x40+i for the priority of source i.
  - A read of an unmapped address, or of a source index of NUM_SRC or more, returns zero.
  - An accepted read gives `rsp_valid` high in the next cycle, with its data.
  - The response holds while `rsp_ready` is low, and `req_ready` equals !rsp_valid || rsp_ready.
  - An accepted write raises no response.
- R3: A secure write to a source priority stores the low 8 bits of the write data. A non-secure write to a group-0 source (`src_group[i]`=0) changes nothing. A non-secure write to a group-1 source stores 0x80 | (data >> 1).
- R4: A non-secure read of a source priority returns (stored << 1) & 0xFF for a group-1 source and 0 for a group-0 source. A secure read returns the stored byte.
- R5: A secure write to the priority mask stores data[7:0]. A non-secure write changes the mask only if the stored bit 7 is set, and then stores 0x80 | (data >> 1).
- R6: Non-secure reads of the priority mask and of the running priority return (value << 1) & 0xFF when bit 7 of the value is set, and 0 otherwise. A secure read of the running priority returns all 9 bits of `run_prio`.
- R7: The binary point registers behave as follows.
  - Binary point writes keep data[2:0].
  - A secure write to 0x02 stores into the primary copy as written.
  - A non-secure write to 0x02 stores into the aliased copy, with a floor of 1.
  - A read of 0x02 returns the primary copy when secure and the aliased copy when non-secure.
- R8: Address 0x03 reads as zero and ignores writes when the access is non-secure, or when groups are absent. Groups are present when REVISION is 2 or HAS_SEC is 1. Otherwise a secure access reads the aliased copy and writes it, with a floor of 1.
- R9: A non-secure read of the interface control returns (stored & 0x402) >> 1. A non-secure write sets bit 1 from data[0]. On revision 2 it also sets bit 10 from data[9]. All other bits keep their value.
- R10: A secure write to the interface control stores data masked by one of four values:
  - revision 1 without the extension: 0x001
  - revision 1 with the extension: 0x01F
  - revision 2 without the extension: 0x21F
  - revision 2 with the extension: 0x61F
- R11: A secure write to the distributor control stores data[1:0] when groups are present, and data[0] alone otherwise. A non-secure read returns stored bit 1 in bit 0. A non-secure write updates only stored bit 1, from data[0].
- R12: With HAS_SEC=0, `req_secure` has no effect and every access takes the secure path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access security attribute, 1 = secure |
| req_addr | input | 7 | Register address |
| req_wdata | input | 11 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 11 | Read data |
| src_group | input | NUM_SRC | Group of each source, 1 = group 1 |
| run_prio | input | 9 | Current running priority from the arbiter |
| ctrl_o | output | 11 | Stored interface control word |
| dist_ctrl_o | output | 2 | Stored distributor group enables |
| prio_mask_o | output | 8 | Stored priority mask |
| bin_point_o | output | 3 | Stored primary binary point |
| alias_bin_point_o | output | 3 | Stored aliased binary point |
| src_prio_o | output | 8*NUM_SRC | Stored source priorities, source i in bits 8i+7:8i |

## Verification
The assertions watch, on every cycle, the properties that hold for any stimulus. These are the handshake (response timing, holding under back-pressure, ready), that non-secure writes never touch bits the secure side owns, that a masked write to a group-0 priority or a lower-half mask leaves storage unchanged, and the floor of 1 on the aliased binary point. Only the bench scenarios show the exact values of each view transform: shifted reads, the value stored for a narrowed write, the control word remapping, the per-revision write masks, and the secure-only behaviour of a build without the extension.

// File: rtl/banked_prio_pkg.sv
package banked_prio_pkg;
  localparam int ADDR_W = 7;
  localparam int REG_W  = 11;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 7'h00;
  localparam logic [ADDR_W-1:0] ADR_PMASK = 7'h01;
  localparam logic [ADDR_W-1:0] ADR_BPT   = 7'h02;
  localparam logic [ADDR_W-1:0] ADR_ABPT  = 7'h03;
  localparam logic [ADDR_W-1:0] ADR_RUN   = 7'h04;
  localparam logic [ADDR_W-1:0] ADR_DCTRL = 7'h05;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_PMASK, SEL_BPT, SEL_ABPT, SEL_RUN, SEL_DCTRL
  } reg_sel_e;

  // Non-secure write value folded into the upper half of the range
  function automatic logic [7:0] fold_upper(input logic [7:0] v);
    return {1'b1, v[7:1]};
  endfunction

  // Non-secure read of a value that is visible only in the upper half
  function automatic logic [7:0] unfold_upper(input logic [7:0] v);
    return v[7] ? {v[6:0], 1'b0} : 8'h00;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_secure_mask(input int rev, input bit sec);
    if (rev == 2) return sec ? 11'h61F : 11'h21F;
    return sec ? 11'h01F : 11'h001;
  endfunction
endpackage

// File: rtl/cpu_if_regs.sv
module cpu_if_regs
  import banked_prio_pkg::*;
#(
  parameter int REVISION = 2,
  parameter bit HAS_SEC  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             ns,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [8:0]       run_prio,
  output logic [10:0]      ctrl_q,
  output logic [7:0]       pmask_q,
  output logic [2:0]       bpt_q,
  output logic [2:0]       abpt_q,
  output logic [1:0]       dctrl_q,
  output logic [REG_W-1:0] rd_data
);
  localparam bit              GROUPS  = (REVISION == 2) || HAS_SEC;
  localparam logic [10:0]     SEC_MSK = ctrl_secure_mask(REVISION, HAS_SEC);
  localparam logic [10:0]     NS_MSK  = (REVISION == 2) ? 11'h402 : 11'h002;

  logic [2:0] bpt_floor1;
  assign bpt_floor1 = (wdata[2:0] == 3'd0) ? 3'd1 : wdata[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pmask_q <= '0;
      bpt_q   <= '0;
      abpt_q  <= '0;
      dctrl_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_CTRL:
          if (ns) ctrl_q <= (ctrl_q & ~NS_MSK) | ({wdata[9:0], 1'b0} & NS_MSK);
          else    ctrl_q <= wdata & SEC_MSK;
        SEL_PMASK:
          if (!ns)             pmask_q <= wdata[7:0];
          else if (pmask_q[7]) pmask_q <= fold_upper(wdata[7:0]);
        SEL_BPT:
          if (ns) abpt_q <= bpt_floor1;
          else    bpt_q  <= wdata[2:0];
        SEL_ABPT:
          if (GROUPS && !ns) abpt_q <= bpt_floor1;
        SEL_DCTRL:
          if (ns)          dctrl_q[1] <= wdata[0];
          else if (GROUPS) dctrl_q    <= wdata[1:0];
          else             dctrl_q    <= {1'b0, wdata[0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (sel)
      SEL_CTRL:  rd_data = ns ? REG_W'((ctrl_q & 11'h402) >> 1) : ctrl_q;
      SEL_PMASK: rd_data = ns ? REG_W'(unfold_upper(pmask_q)) : REG_W'(pmask_q);
      SEL_BPT:   rd_data = ns ? REG_W'(abpt_q) : REG_W'(bpt_q);
      SEL_ABPT:  rd_data = (GROUPS && !ns) ? REG_W'(abpt_q) : '0;
      SEL_RUN:   rd_data = ns ? REG_W'(unfold_upper(run_prio[7:0])) : REG_W'(run_prio);
      SEL_DCTRL: rd_data = ns ? REG_W'(dctrl_q[1]) : REG_W'(dctrl_q);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/src_prio_bank.sv
module src_prio_bank
  import banked_prio_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               ns,
  input  logic               hit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [7:0]         wdata,
  input  logic [NUM_SRC-1:0] group,
  output logic [NUM_SRC*8-1:0] prio_flat,
  output logic [7:0]         rd_data
);
  logic [7:0] prio_q [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[i] <= '0;
      else if (wr_en && hit && idx == IDX_W'(i)) begin
        if (!ns)          prio_q[i] <= wdata;
        else if (group[i]) prio_q[i] <= fold_upper(wdata);
      end
    end
    assign prio_flat[i*8 +: 8] = prio_q[i];
  end

  logic [7:0] sel_prio;
  logic       sel_grp;
  assign sel_prio = prio_q[idx];
  assign sel_grp  = group[idx];

  always_comb begin
    if (!hit)         rd_data = '0;
    else if (!ns)     rd_data = sel_prio;
    else if (sel_grp) rd_data = {sel_prio[6:0], 1'b0};
    else              rd_data = '0;
  end
endmodule

// File: rtl/banked_prio_regs.sv
module banked_prio_regs
  import banked_prio_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int REVISION = 2,
  parameter bit HAS_SEC  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_secure,
  input  logic [6:0]           req_addr,
  input  logic [10:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [10:0]          rsp_data,
  input  logic [NUM_SRC-1:0]   src_group,
  input  logic [8:0]           run_prio,
  output logic [10:0]          ctrl_o,
  output logic [1:0]           dist_ctrl_o,
  output logic [7:0]           prio_mask_o,
  output logic [2:0]           bin_point_o,
  output logic [2:0]           alias_bin_point_o,
  output logic [NUM_SRC*8-1:0] src_prio_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic     fire, wr_en, ns, src_hit;
  reg_sel_e sel;
  logic [REG_W-1:0] if_rd, rd_mux;
  logic [7:0]       src_rd;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_en     = fire && req_write;
  assign ns        = HAS_SEC && !req_secure;
  assign src_hit   = req_addr[6] && (int'(req_addr[5:0]) < NUM_SRC);

  always_comb begin
    unique case (req_addr)
      ADR_CTRL:  sel = SEL_CTRL;
      ADR_PMASK: sel = SEL_PMASK;
      ADR_BPT:   sel = SEL_BPT;
      ADR_ABPT:  sel = SEL_ABPT;
      ADR_RUN:   sel = SEL_RUN;
      ADR_DCTRL: sel = SEL_DCTRL;
      default:   sel = SEL_NONE;
    endcase
  end

  cpu_if_regs #(.REVISION(REVISION), .HAS_SEC(HAS_SEC)) u_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ns(ns), .sel(sel),
    .wdata(req_wdata), .run_prio(run_prio),
    .ctrl_q(ctrl_o), .pmask_q(prio_mask_o), .bpt_q(bin_point_o),
    .abpt_q(alias_bin_point_o), .dctrl_q(dist_ctrl_o), .rd_data(if_rd)
  );

  src_prio_bank #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ns(ns), .hit(src_hit),
    .idx(req_addr[IDX_W-1:0]), .wdata(req_wdata[7:0]), .group(src_group),
    .prio_flat(src_prio_o), .rd_data(src_rd)
  );

  assign rd_mux = src_hit ? REG_W'(src_rd) : if_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/banked_prio_regs_chk.sv
module banked_prio_regs_chk
  import banked_prio_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter bit HAS_SEC = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic                 req_secure,
  input logic [6:0]           req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [10:0]          rsp_data,
  input logic [NUM_SRC-1:0]   src_group,
  input logic [10:0]          ctrl_o,
  input logic [1:0]           dist_ctrl_o,
  input logic [7:0]           prio_mask_o,
  input logic [2:0]           bin_point_o,
  input logic [2:0]           alias_bin_point_o,
  input logic [NUM_SRC*8-1:0] src_prio_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic acc, nsw, grp0_src;
  assign acc = req_valid && req_ready;
  assign nsw = acc && req_write && HAS_SEC && !req_secure;
  assign grp0_src = req_addr[6] && (int'(req_addr[5:0]) < NUM_SRC)
                    && !src_group[req_addr[IDX_W-1:0]];

  assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write |=> rsp_valid);
  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  assert_ready_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  assert_grp0_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nsw && grp0_src |=> $stable(src_prio_o));
  assert_mask_lowhalf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nsw && req_addr == ADR_PMASK && !prio_mask_o[7] |=> $stable(prio_mask_o));
  assert_alias_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nsw && req_addr == ADR_BPT |=> alias_bin_point_o != 3'd0 && $stable(bin_point_o));
  assert_ctrl_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nsw && req_addr == ADR_CTRL |=> $stable(ctrl_o[9:2]) && $stable(ctrl_o[0]));
  assert_dctrl_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nsw && req_addr == ADR_DCTRL |=> $stable(dist_ctrl_o[0]));
endmodule

bind banked_prio_regs banked_prio_regs_chk #(.NUM_SRC(NUM_SRC), .HAS_SEC(HAS_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .src_group(src_group), .ctrl_o(ctrl_o), .dist_ctrl_o(dist_ctrl_o),
  .prio_mask_o(prio_mask_o), .bin_point_o(bin_point_o),
  .alias_bin_point_o(alias_bin_point_o), .src_prio_o(src_prio_o)
);

// File: tb/sim_banked_prio_regs.sv
`timescale 1ns/1ps
module sim_banked_prio_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // DUT u0: 16 sources, revision 2, with security extension
  logic        req_valid = 0, req_write = 0, req_secure = 1, rsp_ready = 1;
  logic [6:0]  req_addr = '0;
  logic [10:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [10:0] rsp_data, ctrl_o;
  logic [15:0] src_group = 16'h00F0;
  logic [8:0]  run_prio = 9'h100;
  logic [1:0]  dist_ctrl_o;
  logic [7:0]  prio_mask_o;
  logic [2:0]  bin_point_o, alias_bin_point_o;
  logic [127:0] src_prio_o;

  banked_prio_regs #(.NUM_SRC(16), .REVISION(2), .HAS_SEC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .src_group(src_group), .run_prio(run_prio),
    .ctrl_o(ctrl_o), .dist_ctrl_o(dist_ctrl_o), .prio_mask_o(prio_mask_o),
    .bin_point_o(bin_point_o), .alias_bin_point_o(alias_bin_point_o),
    .src_prio_o(src_prio_o));

  // DUT u1: 4 sources, revision 1, no security extension
  logic        b_valid = 0, b_write = 0, b_secure = 0;
  logic [6:0]  b_addr = '0;
  logic [10:0] b_wdata = '0;
  logic        b_ready, b_rvalid;
  logic [10:0] b_rdata, b_ctrl;
  logic [1:0]  b_dctrl;
  logic [7:0]  b_pmask;
  logic [2:0]  b_bpt, b_abpt;
  logic [31:0] b_prio;

  banked_prio_regs #(.NUM_SRC(4), .REVISION(1), .HAS_SEC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_write(b_write), .req_secure(b_secure), .req_addr(b_addr),
    .req_wdata(b_wdata), .rsp_valid(b_rvalid), .rsp_ready(1'b1),
    .rsp_data(b_rdata), .src_group(4'b0000), .run_prio(9'h0),
    .ctrl_o(b_ctrl), .dist_ctrl_o(b_dctrl), .prio_mask_o(b_pmask),
    .bin_point_o(b_bpt), .alias_bin_point_o(b_abpt), .src_prio_o(b_prio));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr0(input logic [6:0] a, input logic [10:0] d, input logic sec);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_secure = sec;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd0(input logic [6:0] a, input logic sec, output logic [10:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_secure = sec;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic wr1(input logic [6:0] a, input logic [10:0] d, input logic sec);
    @(negedge clk);
    b_valid = 1; b_write = 1; b_addr = a; b_wdata = d; b_secure = sec;
    @(posedge clk);
    @(negedge clk);
    b_valid = 0; b_write = 0;
  endtask

  task automatic rd1(input logic [6:0] a, input logic sec, output logic [10:0] d);
    @(negedge clk);
    b_valid = 1; b_write = 0; b_addr = a; b_secure = sec;
    @(posedge clk);
    @(negedge clk);
    b_valid = 0;
    d = b_rdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 dist", dist_ctrl_o, 0);
    chk("R1 pmask", prio_mask_o, 0);
    chk("R1 bpt", {bin_point_o, alias_bin_point_o}, 0);
    chk("R1 src", src_prio_o[31:0] | src_prio_o[127:96], 0);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_handshake();
    logic [10:0] d;
    wr0(7'h01, 11'h055, 1);
    chk("R2 write no response", rsp_valid, 0);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 7'h01; req_secure = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R2 rsp_valid", rsp_valid, 1);
    chk("R2 req_ready low", req_ready, 0);
    chk("R2 rsp_data", rsp_data, 11'h055);
    @(negedge clk);
    chk("R2 hold valid", rsp_valid, 1);
    chk("R2 hold data", rsp_data, 11'h055);
    rsp_ready = 1;
    @(negedge clk);
    chk("R2 released", rsp_valid, 0);
    rd0(7'h10, 1, d);
    chk("R2 unmapped", d, 0);
    rd0(7'h50, 1, d);
    chk("R2 source out of range", d, 0);
    wr0(7'h01, 11'h000, 1);
  endtask

  task automatic t_src_prio();
    logic [10:0] d;
    wr0(7'h42, 11'h040, 1);
    chk("R3 secure store", src_prio_o[2*8 +: 8], 8'h40);
    wr0(7'h42, 11'h010, 0);
    chk("R3 ns group0 ignored", src_prio_o[2*8 +: 8], 8'h40);
    wr0(7'h45, 11'h046, 0);
    chk("R3 ns group1 folded", src_prio_o[5*8 +: 8], 8'hA3);
    rd0(7'h45, 0, d);
    chk("R4 ns read group1", d, 11'h046);
    rd0(7'h42, 0, d);
    chk("R4 ns read group0", d, 0);
    rd0(7'h45, 1, d);
    chk("R4 secure read", d, 11'h0A3);
  endtask

  task automatic t_pmask_run();
    logic [10:0] d;
    wr0(7'h01, 11'h0FF, 0);
    chk("R5 ns write lower half ignored", prio_mask_o, 0);
    rd0(7'h01, 0, d);
    chk("R6 ns mask lower half", d, 0);
    wr0(7'h01, 11'h090, 1);
    rd0(7'h01, 0, d);
    chk("R6 ns mask upper half", d, 11'h020);
    wr0(7'h01, 11'h040, 0);
    chk("R5 ns write folded", prio_mask_o, 8'hA0);
    run_prio = 9'h100;
    rd0(7'h04, 0, d);
    chk("R6 ns running idle", d, 0);
    rd0(7'h04, 1, d);
    chk("R6 secure running idle", d, 11'h100);
    run_prio = 9'h0C4;
    rd0(7'h04, 0, d);
    chk("R6 ns running upper", d, 11'h088);
  endtask

  task automatic t_binpoint();
    logic [10:0] d;
    wr0(7'h02, 11'h00F, 1);
    chk("R7 secure primary", bin_point_o, 3'd7);
    wr0(7'h02, 11'h000, 0);
    chk("R7 ns floor", alias_bin_point_o, 3'd1);
    wr0(7'h02, 11'h005, 0);
    chk("R7 ns alias", alias_bin_point_o, 3'd5);
    rd0(7'h02, 0, d);
    chk("R7 ns read alias", d, 11'd5);
    rd0(7'h02, 1, d);
    chk("R7 secure read primary", d, 11'd7);
    wr0(7'h03, 11'h003, 0);
    chk("R8 ns alias addr ignored", alias_bin_point_o, 3'd5);
    rd0(7'h03, 0, d);
    chk("R8 ns alias addr reads 0", d, 0);
    wr0(7'h03, 11'h000, 1);
    chk("R8 secure alias floor", alias_bin_point_o, 3'd1);
    rd0(7'h03, 1, d);
    chk("R8 secure alias read", d, 11'd1);
  endtask

  task automatic t_ctrl();
    logic [10:0] d;
    wr0(7'h00, 11'h7FF, 1);
    chk("R10 rev2 secure mask", ctrl_o, 11'h61F);
    rd0(7'h00, 0, d);
    chk("R9 ns view", d, 11'h201);
    wr0(7'h00, 11'h000, 0);
    chk("R9 ns clears bits 1 and 10", ctrl_o, 11'h21D);
    wr0(7'h00, 11'h200, 0);
    chk("R9 ns sets bit 10 only", ctrl_o, 11'h61D);
  endtask

  task automatic t_dist();
    logic [10:0] d;
    wr0(7'h05, 11'h0FF, 1);
    chk("R11 secure store", dist_ctrl_o, 2'b11);
    rd0(7'h05, 0, d);
    chk("R11 ns read bit1", d, 11'd1);
    wr0(7'h05, 11'h000, 0);
    chk("R11 ns writes bit1 only", dist_ctrl_o, 2'b01);
    rd0(7'h05, 0, d);
    chk("R11 ns read after clear", d, 0);
  endtask

  task automatic t_nosec();
    logic [10:0] d;
    wr1(7'h00, 11'h7FF, 0);
    chk("R10 rev1 nosec mask", b_ctrl, 11'h001);
    wr1(7'h05, 11'h0FF, 1);
    chk("R11 no groups dist", b_dctrl, 2'b01);
    wr1(7'h03, 11'h004, 1);
    chk("R8 no groups alias ignored", b_abpt, 0);
    rd1(7'h03, 1, d);
    chk("R8 no groups alias reads 0", d, 0);
    wr1(7'h02, 11'h000, 0);
    chk("R12 nonsecure attr takes primary", {b_bpt, b_abpt}, 0);
    wr1(7'h40, 11'h033, 0);
    chk("R12 group0 write stored", b_prio[7:0], 8'h33);
    wr1(7'h01, 11'h044, 0);
    chk("R12 mask written as is", b_pmask, 8'h44);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_handshake();
    t_src_prio();
    t_pmask_run();
    t_binpoint();
    t_ctrl();
    t_dist();
    t_nosec();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc == 20000);
    checks++;
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule